// File: doc/BRIEF.md
# CPU Clock Divider with DMA Clock-Stretch Halt

This block derives the processor clock from the fast video master clock by dividing it by one of two ratios chosen with a speed-select input. Each processor cycle is reported as a level (`cpu_clk`) and as two one-tick enable pulses: one at the start of the low phase and one at the start of the high phase. A video DMA engine requests the bus by pulling `halt_n` low. The block does not signal the processor to wait. It stops the processor clock itself. The processor can therefore be frozen between any two of its clock cycles, including in the middle of a multi-cycle instruction. It is never frozen partway through one of its own cycles.

The processor cycle that is under way when the request arrives runs to its end. The clock then stays frozen low and `bus_grant` stays high for as long as the request is held. When the request is released, `bus_grant` drops one master tick before the processor clock restarts at the start of a fresh, full-length cycle. The time from request to grant depends on where in the processor cycle the request lands. The block reports that time on `lat_cnt`, in master ticks, so the video timing can be checked.

Top module: `cpuclk_halt_top`

## Requirements
- R1: While `rst` is high, and at the first sample after it is released, `bus_grant` is 0 and `lat_cnt` is 0. The slow ratio is selected, so the period of `phi1_en` is 6 ticks.
- R2: With `spd_fast`=0, a processor cycle lasts 6 master ticks. `phi1_en` pulses on the first tick of the cycle and `phi2_en` pulses 3 ticks after it. `cpu_clk` is 0 for the first 3 ticks and 1 for the last 3.
- R3: With `spd_fast`=1, a processor cycle lasts 4 master ticks, and `phi2_en` pulses 2 ticks after `phi1_en`.
- R4: A change on `spd_fast` never shortens or lengthens the cycle that is under way. It takes effect at the next cycle boundary.
- R5: A request seen on tick position k of a cycle of length D (k=0 is the `phi1_en` tick) leads to `bus_grant` going high exactly D-k ticks later. This means the grant comes only after the last tick of the current cycle.
- R6: `lat_cnt` counts the master ticks from the request to the grant. While `bus_grant` is high it holds D-k, which lies between 1 and D.
- R7: While `bus_grant` is high, for as long as `halt_n` stays low, `phi1_en` and `phi2_en` stay 0 and `cpu_clk` stays 0.
- R8: After `halt_n` returns high, `bus_grant` falls on the next tick. `phi1_en` then pulses on the tick after that, not before.
- R9: The first processor cycle after a release has full length. `phi2_en` follows the restart `phi1_en` by D/2 ticks, and the next `phi1_en` follows it by D ticks.
- R10: A request withdrawn before the end of the current cycle causes no halt. `bus_grant` stays 0 and `lat_cnt` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video master clock |
| rst | input | 1 | Synchronous active-high reset |
| spd_fast | input | 1 | 1 selects the fast ratio (divide by 4), 0 the slow ratio (divide by 6) |
| halt_n | input | 1 | Active-low bus request from the DMA engine |
| cpu_clk | output | 1 | Processor clock level |
| phi1_en | output | 1 | One-tick pulse at the start of a processor cycle |
| phi2_en | output | 1 | One-tick pulse at the start of the high phase |
| bus_grant | output | 1 | High while the processor clock is frozen |
| lat_cnt | output | 4 | Master ticks from request to grant |

## Verification
The hardest case to reach is a request landing on each individual tick position within the processor cycle, at both ratios. The grant delay, and whether the restart is clean, depend on that position. The stimulus first settles the speed. It then locks onto a `phi1_en` pulse and counts a chosen number of ticks before it drops `halt_n`. The sweep covers every position for both ratios. A request withdrawn inside the cycle, and a speed change in mid-cycle, are placed the same way.

// File: rtl/cpuclk_halt_pkg.sv
package cpuclk_halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_WAKE = 2'd2
    } hstate_t;

    typedef struct packed {
        logic lvl;
        logic rise_en;
        logic fall_en;
    } phase_t;

    function automatic int unsigned last_tick_of(input logic fast, input int unsigned d_fast,
                                                 input int unsigned d_slow);
        return fast ? d_fast - 1 : d_slow - 1;
    endfunction

    function automatic int unsigned half_of(input logic fast, input int unsigned d_fast,
                                            input int unsigned d_slow);
        return fast ? d_fast / 2 : d_slow / 2;
    endfunction

endpackage

// File: rtl/cpuclk_divider.sv
module cpuclk_divider
    import cpuclk_halt_pkg::*;
#(
    parameter int unsigned DIV_FAST = 4,
    parameter int unsigned DIV_SLOW = 6,
    parameter int unsigned CNT_W    = $clog2(DIV_SLOW)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   spd_fast,
    input  logic   freeze,
    output phase_t ph,
    output logic   last_tick
);
    localparam logic [CNT_W-1:0] F_LAST = CNT_W'(DIV_FAST - 1);
    localparam logic [CNT_W-1:0] S_LAST = CNT_W'(DIV_SLOW - 1);
    localparam logic [CNT_W-1:0] F_HALF = CNT_W'(DIV_FAST / 2);
    localparam logic [CNT_W-1:0] S_HALF = CNT_W'(DIV_SLOW / 2);

    logic [CNT_W-1:0] cnt_q;
    logic             fast_q;
    logic [CNT_W-1:0] last_v;
    logic [CNT_W-1:0] half_v;

    assign last_v    = fast_q ? F_LAST : S_LAST;
    assign half_v    = fast_q ? F_HALF : S_HALF;
    assign last_tick = !freeze && (cnt_q == last_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fast_q <= 1'b0;
        end else if (freeze) begin
            cnt_q  <= '0;
            fast_q <= spd_fast;
        end else if (cnt_q == last_v) begin
            cnt_q  <= '0;
            fast_q <= spd_fast;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ph.rise_en = !freeze && (cnt_q == '0);
        ph.fall_en = !freeze && (cnt_q == half_v);
        ph.lvl     = !freeze && (cnt_q >= half_v);
    end

    // R4: the tick count of a cycle stays within the latched ratio
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_v);

    // R2 / R3: a cycle start is always preceded by a last tick or a frozen tick
    assert_start_after_end_R2: assert property (@(posedge clk) disable iff (rst)
        (!freeze && $past(!rst) && cnt_q == '0) |-> ($past(cnt_q) == $past(last_v) || $past(freeze)));

endmodule

// File: rtl/cpuclk_halt_fsm.sv
module cpuclk_halt_fsm
    import cpuclk_halt_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 6,
    parameter int unsigned LAT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_n,
    input  logic             last_tick,
    input  phase_t           ph,
    output logic             freeze,
    output logic             grant,
    output logic [LAT_W-1:0] lat
);
    hstate_t          st_q;
    logic [LAT_W-1:0] lat_q;
    logic             req;

    assign req    = !halt_n;
    assign freeze = (st_q != ST_RUN);
    assign grant  = (st_q == ST_HOLD);
    assign lat    = lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            lat_q <= '0;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (req) begin
                        if (lat_q != '1) lat_q <= lat_q + 1'b1;
                        if (last_tick) st_q <= ST_HOLD;
                    end else begin
                        lat_q <= '0;
                    end
                end
                ST_HOLD: begin
                    if (!req) st_q <= ST_WAKE;
                end
                ST_WAKE: begin
                    st_q  <= ST_RUN;
                    lat_q <= '0;
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    // R7: no processor clock activity while the bus is granted
    assert_no_edge_in_grant_R7: assert property (@(posedge clk) disable iff (rst)
        grant |-> (!ph.rise_en && !ph.fall_en && !ph.lvl));

    // R5: a grant begins only right after the last tick of a cycle
    assert_grant_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(grant) && $past(!rst)) |-> $past(last_tick));

    // R8: the restart pulse comes one tick after the grant drops
    assert_restart_after_drop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(grant) |=> ph.rise_en);

    // R6: latency held during a grant lies within one cycle length
    assert_lat_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        grant |-> (lat_q >= 1 && lat_q <= LAT_W'(DIV_SLOW)));

endmodule

// File: rtl/cpuclk_halt_top.sv
module cpuclk_halt_top
    import cpuclk_halt_pkg::*;
#(
    parameter int unsigned DIV_FAST = 4,
    parameter int unsigned DIV_SLOW = 6,
    parameter int unsigned LAT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spd_fast,
    input  logic             halt_n,
    output logic             cpu_clk,
    output logic             phi1_en,
    output logic             phi2_en,
    output logic             bus_grant,
    output logic [LAT_W-1:0] lat_cnt
);
    localparam int unsigned CNT_W = $clog2(DIV_SLOW);

    phase_t ph;
    logic   last_tick;
    logic   freeze;

    cpuclk_divider #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW),
        .CNT_W    (CNT_W)
    ) div_i (
        .clk       (clk),
        .rst       (rst),
        .spd_fast  (spd_fast),
        .freeze    (freeze),
        .ph        (ph),
        .last_tick (last_tick)
    );

    cpuclk_halt_fsm #(
        .DIV_SLOW (DIV_SLOW),
        .LAT_W    (LAT_W)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .halt_n    (halt_n),
        .last_tick (last_tick),
        .ph        (ph),
        .freeze    (freeze),
        .grant     (bus_grant),
        .lat       (lat_cnt)
    );

    assign cpu_clk = ph.lvl;
    assign phi1_en = ph.rise_en;
    assign phi2_en = ph.fall_en;

endmodule

// File: tb/cpuclk_halt_top_tb_top.sv
module cpuclk_halt_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spd_fast = 1'b0;
    logic       halt_n = 1'b1;
    logic       cpu_clk, phi1_en, phi2_en, bus_grant;
    logic [3:0] lat_cnt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cpuclk_halt_top dut_i (
        .clk(clk), .rst(rst), .spd_fast(spd_fast), .halt_n(halt_n),
        .cpu_clk(cpu_clk), .phi1_en(phi1_en), .phi2_en(phi2_en),
        .bus_grant(bus_grant), .lat_cnt(lat_cnt)
    );

    // {speed, tick position k, expected latency}
    localparam logic [7:0] VEC [10] = '{
        {1'b0, 3'd0, 4'd6}, {1'b0, 3'd1, 4'd5}, {1'b0, 3'd2, 4'd4},
        {1'b0, 3'd3, 4'd3}, {1'b0, 3'd4, 4'd2}, {1'b0, 3'd5, 4'd1},
        {1'b1, 3'd0, 4'd4}, {1'b1, 3'd1, 4'd3}, {1'b1, 3'd2, 4'd2},
        {1'b1, 3'd3, 4'd1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic spd);
        rst = 1'b1; halt_n = 1'b1; spd_fast = spd;
        tick(); tick();
        rst = 1'b0;
    endtask

    // advance until a phi1_en sample; returns ticks taken
    task automatic to_phi1(output int n);
        n = 0;
        do begin tick(); n++; end while (!phi1_en && n < 40);
    endtask

    task automatic settle(input logic spd);
        int n;
        do_reset(spd);
        to_phi1(n);
        to_phi1(n);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n, d, k, el, m, bad;
        logic sp;
        // R1 reset state
        do_reset(1'b0);
        check("R1 grant", bus_grant, 0);
        check("R1 lat", lat_cnt, 0);
        to_phi1(n);
        to_phi1(n);
        check("R1 slow period", n, 6);

        // R2 slow phases
        m = 0; bad = 0;
        for (int i = 0; i < 6; i++) begin
            if (phi2_en) m = i;
            if (cpu_clk != (i >= 3)) bad++;
            tick();
        end
        check("R2 phi2 offset", m, 3);
        check("R2 level shape", bad, 0);
        check("R2 period", int'(phi1_en), 1);

        // R3 fast phases
        settle(1'b1);
        m = 0;
        for (int i = 0; i < 4; i++) begin
            if (phi2_en) m = i;
            tick();
        end
        check("R3 phi2 offset", m, 2);
        to_phi1(n);
        check("R3 fast period", n, 4);

        // R4 speed change mid-cycle
        settle(1'b0);
        tick(); tick();
        spd_fast = 1'b1;
        to_phi1(n);
        check("R4 current cycle kept", n, 4);
        to_phi1(n);
        check("R4 new ratio next cycle", n, 4);

        // Table sweep: R5 R6 R7 R8 R9
        for (int v = 0; v < 10; v++) begin
            sp = VEC[v][7];
            k  = int'(VEC[v][6:4]);
            el = int'(VEC[v][3:0]);
            d  = sp ? 4 : 6;
            settle(sp);
            for (int i = 0; i < k; i++) tick();
            halt_n = 1'b0;
            n = 0;
            do begin tick(); n++; end while (!bus_grant && n < 20);
            check($sformatf("R5 grant delay v%0d", v), n, el);
            check($sformatf("R6 latency v%0d", v), lat_cnt, el);
            bad = 0;
            for (int i = 0; i < 5; i++) begin
                if (phi1_en || phi2_en || cpu_clk || !bus_grant) bad++;
                tick();
            end
            check($sformatf("R7 frozen v%0d", v), bad, 0);
            halt_n = 1'b1;
            tick();
            check($sformatf("R8 grant drop v%0d", v), int'(bus_grant) + 2 * int'(phi1_en), 0);
            tick();
            check($sformatf("R8 restart v%0d", v), int'(phi1_en), 1);
            m = 0;
            do begin tick(); m++; end while (!phi2_en && m < 20);
            check($sformatf("R9 phi2 after restart v%0d", v), m, d / 2);
            to_phi1(n);
            check($sformatf("R9 full cycle v%0d", v), m + n, d);
        end

        // R10 withdrawn request
        settle(1'b0);
        tick();
        halt_n = 1'b0;
        tick(); tick();
        halt_n = 1'b1;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (bus_grant) bad++;
        end
        check("R10 no grant", bad, 0);
        check("R10 lat cleared", lat_cnt, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule